// File: doc/BRIEF.md
# Synchronous Memory Port with Burst Address Counter

This block is a single clocked access port onto an on-chip word array. Each access uses an address held in an internal counter. On every rising clock edge three active-low strobes set what the counter does: return to zero, take the external address, step up by one, or keep its value. A host can start a burst by loading a start address once and then stepping through consecutive words with one strobe. It does not need to drive a new address on every cycle.

The port is selected when one chip enable is low and the other is high. When selected, a high read/write line reads and a low one writes. The read path can be built as flow-through, where data follows the same clock edge, or as pipelined, where one extra register stage is added. An asynchronous output enable blanks the data output at once. The output is modelled as a plain bus with a valid flag. When the flag is low the bus is parked at zero, which stands for high impedance.

Top module: `sbp_port`

## Requirements
- R1: With `cnt_rst_n` low at a clock edge, the counter becomes zero and that edge's access uses address zero. This control wins over all others.
- R2: With `cnt_rst_n` high and `load_n` low, the counter takes `addr_in`, and the access uses that address.
- R3: With `cnt_rst_n` and `load_n` high and `step_n` low, the counter steps up by one, and the access uses the stepped address. `addr_in` has no effect.
- R4: With all three counter strobes high, the counter keeps its value. The access uses the kept address, and `addr_in` has no effect.
- R5: Stepping from the highest address (all ones over `ADDR_W` bits) gives address zero.
- R6: The counter follows R1 to R4 whether or not the port is selected.
- R7: The port is selected only when `sel0_n` is low and `sel1` is high. An access made while deselected leaves `dout_vld` low and `dout` zero.
- R8: A selected access with `rd_wr_n` low stores `din` at the access address. The output stays invalid for that access.
- R9: With `PIPELINED`=0, a selected read shows `dout_vld` high and the stored word on `dout` right after the same clock edge.
- R10: With `PIPELINED`=1, each read result, and each change of selection, reaches the outputs one clock edge later than with `PIPELINED`=0.
- R11: While `oe_n` is high, `dout_vld` is low and `dout` is zero at once, with no clock edge needed. Lowering `oe_n` restores the pending result.
- R12: While `rst` is high at a clock edge, the counter clears to zero and both output stages become invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External start address for a load |
| din | input | DATA_W | Write data |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| rd_wr_n | input | 1 | High reads, low writes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| load_n | input | 1 | Load counter from `addr_in`, active low |
| step_n | input | 1 | Step counter up by one, active low |
| cnt_rst_n | input | 1 | Clear counter, active low |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data is driven (stands for not high impedance) |

## Verification
Counter moves and writes take effect on the clock edge where the strobes are sampled. A flow-through read is visible one sample point after that edge, and the pipelined read one edge later again. The bench drives each access on the falling edge and samples 1 ns after the next rising edge. Two instances, one per read mode, run the same stimulus: the flow-through one is compared with the result of the current access, and the pipelined one with the result kept from the previous access. The output-enable checks change `oe_n` between edges and sample 0.5 ns later, with no clock edge in between.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        CM_CLEAR = 2'd0,
        CM_LOAD  = 2'd1,
        CM_STEP  = 2'd2,
        CM_KEEP  = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic sel;
        logic rd;
    } acc_t;

    function automatic cnt_mode_e decode_mode(input logic clr_n,
                                              input logic ld_n,
                                              input logic stp_n);
        cnt_mode_e m;
        if (!clr_n)      m = CM_CLEAR;
        else if (!ld_n)  m = CM_LOAD;
        else if (!stp_n) m = CM_STEP;
        else             m = CM_KEEP;
        return m;
    endfunction

    function automatic acc_t decode_access(input logic s0_n,
                                           input logic s1,
                                           input logic rw_n);
        acc_t a;
        a.sel = !s0_n && s1;
        a.rd  = rw_n;
        return a;
    endfunction

endpackage

// File: rtl/sbp_addr_counter.sv
module sbp_addr_counter
    import sbp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] cnt_d,
    output logic [ADDR_W-1:0] cnt_q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        unique case (mode)
            CM_CLEAR: cnt_d = '0;
            CM_LOAD:  cnt_d = load_val;
            CM_STEP:  cnt_d = cnt_q + ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sbp_mem_array.sv
module sbp_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sbp_out_stage.sv
module sbp_out_stage #(
    parameter int DATA_W    = 16,
    parameter bit PIPELINED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              flow_vld,
    input  logic [DATA_W-1:0] flow_data,
    output logic              dout_vld,
    output logic [DATA_W-1:0] dout
);
    logic              stage_vld;
    logic [DATA_W-1:0] stage_data;

    generate
        if (PIPELINED) begin : g_pipe
            logic              pq_vld;
            logic [DATA_W-1:0] pq_data;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pq_vld  <= 1'b0;
                    pq_data <= '0;
                end else begin
                    pq_vld  <= flow_vld;
                    pq_data <= flow_vld ? flow_data : '0;
                end
            end
            assign stage_vld  = pq_vld;
            assign stage_data = pq_data;
        end else begin : g_flow
            assign stage_vld  = flow_vld;
            assign stage_data = flow_data;
        end
    endgenerate

    assign dout_vld = stage_vld && !oe_n;
    assign dout     = dout_vld ? stage_data : '0;
endmodule

// File: rtl/sbp_port.sv
module sbp_port
    import sbp_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter bit PIPELINED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] din,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              rd_wr_n,
    input  logic              oe_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              cnt_rst_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    cnt_mode_e         mode;
    acc_t              acc_d;
    acc_t              acc_q;
    logic [ADDR_W-1:0] cnt_d;
    logic [ADDR_W-1:0] cnt_q;
    logic              wr_en;
    logic [DATA_W-1:0] rdata;
    logic              flow_vld;
    logic [DATA_W-1:0] flow_data;

    assign mode  = decode_mode(cnt_rst_n, load_n, step_n);
    assign acc_d = decode_access(sel0_n, sel1, rd_wr_n);
    assign wr_en = !rst && acc_d.sel && !acc_d.rd;

    sbp_addr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .load_val (addr_in),
        .cnt_d    (cnt_d),
        .cnt_q    (cnt_q)
    );

    sbp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (cnt_d),
        .wdata (din),
        .raddr (cnt_q),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign flow_vld  = acc_q.sel && acc_q.rd;
    assign flow_data = flow_vld ? rdata : '0;

    sbp_out_stage #(.DATA_W(DATA_W), .PIPELINED(PIPELINED)) u_out (
        .clk       (clk),
        .rst       (rst),
        .oe_n      (oe_n),
        .flow_vld  (flow_vld),
        .flow_data (flow_data),
        .dout_vld  (dout_vld),
        .dout      (dout)
    );
endmodule

// File: rtl/sbp_port_chk.sv
module sbp_port_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter bit PIPELINED = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              sel0_n,
    input logic              sel1,
    input logic              rd_wr_n,
    input logic              oe_n,
    input logic              load_n,
    input logic              step_n,
    input logic              cnt_rst_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic [ADDR_W-1:0] cnt_q
);
    // R1
    a_r1_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !cnt_rst_n |=> cnt_q == '0);

    // R2
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (cnt_rst_n && !load_n) |=> cnt_q == $past(addr_in));

    // R3, R5
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_rst_n && load_n && !step_n) |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));

    // R4
    a_r4_keep: assert property (@(posedge clk) disable iff (rst)
        (cnt_rst_n && load_n && step_n) |=> $stable(cnt_q));

    // R11
    a_r11_oe_blanks: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!dout_vld && dout == '0));

    // R12
    a_r12_reset: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !dout_vld));

    generate
        if (PIPELINED) begin : g_pipe_chk
            // R7, R10
            a_r7_desel_quiet: assert property (@(posedge clk) disable iff (rst)
                (sel0_n || !sel1) |=> ##1 !dout_vld);
            // R8, R10
            a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
                (!sel0_n && sel1 && !rd_wr_n) |=> ##1 !dout_vld);
        end else begin : g_flow_chk
            // R7
            a_r7_desel_quiet: assert property (@(posedge clk) disable iff (rst)
                (sel0_n || !sel1) |=> !dout_vld);
            // R8
            a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
                (!sel0_n && sel1 && !rd_wr_n) |=> !dout_vld);
        end
    endgenerate
endmodule

bind sbp_port sbp_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPELINED(PIPELINED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_in   (addr_in),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .rd_wr_n   (rd_wr_n),
    .oe_n      (oe_n),
    .load_n    (load_n),
    .step_n    (step_n),
    .cnt_rst_n (cnt_rst_n),
    .dout      (dout),
    .dout_vld  (dout_vld),
    .cnt_q     (cnt_q)
);

// File: tb/sbp_port_test.sv
module sbp_port_test;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] din = '0;
    logic          sel0_n = 1'b1, sel1 = 1'b0, rd_wr_n = 1'b1, oe_n = 1'b0;
    logic          load_n = 1'b1, step_n = 1'b1, cnt_rst_n = 1'b1;
    logic [DW-1:0] dout_f, dout_p;
    logic          vld_f, vld_p;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_cnt = '0;
    logic [DW-1:0] m_mem [1 << AW];
    logic          prev_vld = 1'b0;
    logic [DW-1:0] prev_dat = '0;

    always #2.5 clk = ~clk;

    sbp_port #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b0)) uut (
        .clk(clk), .rst(rst), .addr_in(addr_in), .din(din),
        .sel0_n(sel0_n), .sel1(sel1), .rd_wr_n(rd_wr_n), .oe_n(oe_n),
        .load_n(load_n), .step_n(step_n), .cnt_rst_n(cnt_rst_n),
        .dout(dout_f), .dout_vld(vld_f)
    );

    sbp_port #(.ADDR_W(AW), .DATA_W(DW), .PIPELINED(1'b1)) uut_pipe (
        .clk(clk), .rst(rst), .addr_in(addr_in), .din(din),
        .sel0_n(sel0_n), .sel1(sel1), .rd_wr_n(rd_wr_n), .oe_n(oe_n),
        .load_n(load_n), .step_n(step_n), .cnt_rst_n(cnt_rst_n),
        .dout(dout_p), .dout_vld(vld_p)
    );

    task automatic check(input string tag, input logic av, input logic [DW-1:0] ad,
                         input logic ev, input logic [DW-1:0] ed);
        total++;
        if (av !== ev || ad !== ed) begin
            bad++;
            $display("FAIL %s: actual vld=%b data=%h expected vld=%b data=%h",
                     tag, av, ad, ev, ed);
        end
    endtask

    // One access: drive on the falling edge, sample 1 ns after the rising edge.
    task automatic step(input string tag, input bit clr_n, input bit ld_n, input bit stp_n,
                        input logic [AW-1:0] a, input bit s0n, input bit s1,
                        input bit rwn, input logic [DW-1:0] d);
        logic          sel, fv;
        logic [DW-1:0] fd;
        @(negedge clk);
        cnt_rst_n = clr_n; load_n = ld_n; step_n = stp_n; addr_in = a;
        sel0_n = s0n; sel1 = s1; rd_wr_n = rwn; din = d; oe_n = 1'b0;
        if (!clr_n)      m_cnt = '0;
        else if (!ld_n)  m_cnt = a;
        else if (!stp_n) m_cnt = m_cnt + 1'b1;
        sel = !s0n && s1;
        if (sel && !rwn) m_mem[m_cnt] = d;
        fv = sel && rwn;
        fd = fv ? m_mem[m_cnt] : '0;
        @(posedge clk);
        #1;
        check({tag, " flow"}, vld_f, dout_f, fv, fd);
        check({tag, " R10 pipe"}, vld_p, dout_p, prev_vld, prev_dat);
        prev_vld = fv;
        prev_dat = fd;
    endtask

    task automatic wr(input string tag, input bit ld_n, input bit stp_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(tag, 1'b1, ld_n, stp_n, a, 1'b0, 1'b1, 1'b0, d);
    endtask

    task automatic rd(input string tag, input bit clr_n, input bit ld_n, input bit stp_n,
                      input logic [AW-1:0] a);
        step(tag, clr_n, ld_n, stp_n, a, 1'b0, 1'b1, 1'b1, '0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R12 reset flow", vld_f, dout_f, 1'b0, '0);
        check("R12 reset pipe", vld_p, dout_p, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0; prev_vld = 1'b0; prev_dat = '0;
        // write with the counter kept: lands at address zero after reset
        wr("R12 keep-write", 1'b1, 1'b1, 8'h77, 16'hA5A5);
        rd("R12 read addr0", 1'b1, 1'b0, 1'b1, 8'h00);
    endtask

    task automatic t_burst;
        wr("R2 R8 load-write", 1'b0, 1'b1, 8'h10, 16'h1000);
        for (int i = 1; i < 6; i++)
            wr("R3 R8 step-write", 1'b1, 1'b0, 8'hEE, 16'h1000 + 16'(i));
        rd("R2 R9 load-read", 1'b1, 1'b0, 1'b1, 8'h10);
        for (int i = 1; i < 6; i++)
            rd("R3 R9 step-read", 1'b1, 1'b1, 1'b0, 8'h33);
    endtask

    task automatic t_keep;
        rd("R4 keep-read", 1'b1, 1'b1, 1'b1, 8'h12);
        rd("R4 keep-read again", 1'b1, 1'b1, 1'b1, 8'h00);
        wr("R4 R8 keep-overwrite", 1'b1, 1'b1, 8'h01, 16'hBEEF);
        rd("R4 read back", 1'b1, 1'b1, 1'b1, 8'h02);
    endtask

    task automatic t_wrap;
        wr("R5 load top", 1'b0, 1'b1, 8'hFF, 16'hF0F0);
        wr("R5 step wraps", 1'b1, 1'b0, 8'h44, 16'h0F0F);
        rd("R5 read top", 1'b1, 1'b0, 1'b1, 8'hFF);
        rd("R5 read wrapped", 1'b1, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_clear;
        wr("R1 prep", 1'b0, 1'b1, 8'h01, 16'h0101);
        rd("R1 clear beats load", 1'b0, 1'b0, 1'b0, 8'h10);
        rd("R1 step after clear", 1'b1, 1'b1, 1'b0, 8'h10);
    endtask

    task automatic t_desel;
        rd("R9 select", 1'b1, 1'b0, 1'b1, 8'h10);
        step("R6 R7 desel ce0", 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, '0);
        step("R6 R7 desel ce1", 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, '0);
        step("R7 desel write ignored", 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 16'hDEAD);
        rd("R6 R7 reselect", 1'b1, 1'b1, 1'b1, 8'h00);
        rd("R10 back-to-back", 1'b1, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic t_oe;
        rd("R11 setup", 1'b1, 1'b0, 1'b1, 8'h11);
        oe_n = 1'b1;
        #0.5;
        check("R11 oe high flow", vld_f, dout_f, 1'b0, '0);
        check("R11 oe high pipe", vld_p, dout_p, 1'b0, '0);
        oe_n = 1'b0;
        #0.5;
        check("R11 oe low flow", vld_f, dout_f, 1'b1, 16'h1001);
    endtask

    initial begin
        t_reset();
        t_burst();
        t_keep();
        t_wrap();
        t_clear();
        t_desel();
        t_oe();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule